// File: doc/BRIEF.md
# UART Receiver with Error-Tagged Receive Queue

This block is the receive half of a UART. It oversamples the incoming serial line at sixteen times the bit rate, finds and validates start bits, assembles characters of 5 to 8 bits, checks an optional parity bit and the stop bit, and stores each finished character together with its own framing and parity flags. In queue mode the characters wait in a 16-entry, 10-bit-wide first-in first-out store. In single-buffer mode only the most recent character is kept.

Software or a neighbouring block reads one character per `rd_i` pulse. The read word holds the character and its two flags, plus a single global overrun flag. The overrun flag is not stored per entry: it is one sticky bit, set when a character finishes while the queue is full and cleared by any read. The divisor and the framing settings are shared inputs, driven from the same control source as the transmitter.

The receive controller has five states. ST_IDLE waits for a high-to-low step on the synchronised line (transition *start-seen* goes to ST_START). ST_START counts eight oversampling ticks and then samples the line again. A high sample is *false-start* and returns to ST_IDLE. A low sample is *start-confirmed* and goes to ST_DATA. ST_DATA samples one bit every sixteen ticks. After the last data bit it takes *data-done*, to ST_PARITY when parity is on or to ST_STOP when it is off. ST_PARITY samples one bit and takes *parity-done* to ST_STOP. ST_STOP samples the stop bit, reports the character and takes *frame-done* back to ST_IDLE.

Top module: `uart_rx_err_fifo`

## Requirements
- R1: After reset, `rd_data_o` is all zeros and `rx_avail_o` is low.
- R2: Data bits are taken least significant bit first. The word length is set by `wlen_i`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits 7:0 of the read word carry the character, and bits above the word length read as zero.
- R3: With `fifo_en_i` high, finished characters are queued and read back in arrival order, up to 16 of them. `rx_avail_o` is high while the queue is not empty.
- R4: The queue never holds more than 16 entries. A character that finishes while the queue is full, with no pop in the same cycle, is dropped, and the queued entries are kept unchanged.
- R5: Bit 8 of the read word is the framing flag. It is set when the stop bit sampled at its middle is low.
- R6: Bit 9 of the read word is the parity flag. It is set only when `par_en_i` is high and the ones count of the data bits plus the parity bit is odd with `par_even_i`=1, or even with `par_even_i`=0.
- R7: Bit 10 of the read word is the overrun flag. It is set by the drop in R4 and stays set until a read. The first read after the drop returns it as 1, and that read clears it.
- R8: A read of an empty queue returns the last popped bits 9:0, leaves the queue unchanged and still clears overrun.
- R9: With `fifo_en_i` low, each new character overwrites a single buffer and overrun is never set. `rx_avail_o` is high from the arrival of a character until the next read. A read returns the buffer contents.
- R10: A low pulse on `rx_i` shorter than half a bit time does not produce a character.
- R11: `rd_data_o` takes its new value in the clock cycle after the cycle in which `rd_i` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| div_i | input | 12 | Oversampling divisor; one tick every div_i+1 clocks |
| wlen_i | input | 2 | Word length select (00=5 ... 11=8 bits) |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| fifo_en_i | input | 1 | 1 = 16-entry queue, 0 = single buffer |
| rd_i | input | 1 | Read strobe; pops one entry and clears overrun |
| rd_data_o | output | 11 | {overrun, parity flag, framing flag, data[7:0]} |
| rx_avail_o | output | 1 | Unread character present |

## Verification
The bench fills the queue to its limit and sends a seventeenth character. A design that overwrote an entry or let the pointers wrap would return the wrong sequence, and one that forgot the sticky bit would report no overrun on the first read. It reads the empty queue after draining it: a design that moved its pointers there would return stale or garbage data. It sends short words with all-ones data, so upper bits that are not cleared show up. It injects bad parity in both parity senses and a low stop bit, so a wrong flag position or polarity is caught. A short low glitch on the idle line catches a receiver that trusts the edge without checking the line again at mid-bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic       perr;
        logic       ferr;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/urx_tick_gen.sv
module urx_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= div_i;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic [1:0] wlen_i,
    input  logic       par_en_i,
    input  logic       par_even_i,
    output logic       done_o,
    output rx_entry_t  entry_o
);
    localparam logic [3:0] MID_TICK  = 4'd7;
    localparam logic [3:0] LAST_TICK = 4'd15;

    rx_state_e  st_q, st_d;
    logic [3:0] tcnt_q;
    logic [2:0] bidx_q;
    logic [7:0] shreg_q;
    logic       pbit_q;
    logic       rx_prev_q;
    logic       fall;
    logic [2:0] last_bit;
    logic       at_last;

    assign fall     = rx_prev_q & ~rx_i;
    assign last_bit = {1'b0, wlen_i} + 3'd4;
    assign at_last  = tick_i && (tcnt_q == LAST_TICK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (fall) st_d = ST_START;
            ST_START:  if (tick_i && tcnt_q == MID_TICK)
                           st_d = rx_i ? ST_IDLE : ST_DATA;
            ST_DATA:   if (at_last && bidx_q == last_bit)
                           st_d = par_en_i ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_last) st_d = ST_STOP;
            ST_STOP:   if (at_last) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q    <= '0;
            bidx_q    <= '0;
            shreg_q   <= '0;
            pbit_q    <= 1'b0;
            rx_prev_q <= 1'b1;
            done_o    <= 1'b0;
            entry_o   <= '0;
        end else begin
            rx_prev_q <= rx_i;
            done_o    <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    tcnt_q <= '0;
                    bidx_q <= '0;
                    if (fall) shreg_q <= '0;
                end
                ST_START: if (tick_i)
                    tcnt_q <= (tcnt_q == MID_TICK) ? 4'd0 : tcnt_q + 4'd1;
                ST_DATA: if (tick_i) begin
                    tcnt_q <= tcnt_q + 4'd1;
                    if (tcnt_q == LAST_TICK) begin
                        shreg_q[bidx_q] <= rx_i;
                        bidx_q          <= bidx_q + 3'd1;
                    end
                end
                ST_PARITY: if (tick_i) begin
                    tcnt_q <= tcnt_q + 4'd1;
                    if (tcnt_q == LAST_TICK) pbit_q <= rx_i;
                end
                ST_STOP: if (tick_i) begin
                    tcnt_q <= tcnt_q + 4'd1;
                    if (tcnt_q == LAST_TICK) begin
                        done_o       <= 1'b1;
                        entry_o.data <= shreg_q;
                        entry_o.ferr <= ~rx_i;
                        entry_o.perr <= par_en_i & ((^shreg_q) ^ pbit_q ^ ~par_even_i);
                    end
                end
                default: tcnt_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/urx_store.sv
module urx_store
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en_i,
    input  logic          push_i,
    input  rx_entry_t     push_entry_i,
    input  logic          rd_i,
    output logic [10:0]   rd_data_o,
    output logic          avail_o,
    output logic [AW:0]   level_o,
    output logic          ovr_o
);
    localparam logic [AW:0] FULL_LVL = DEPTH[AW:0];

    rx_entry_t        mem [DEPTH];
    rx_entry_t        buf_q;
    logic             bvalid_q;
    logic [AW-1:0]    wp_q, rp_q;
    logic [AW:0]      count_q;
    logic             pop, push_ok, drop;

    always_comb begin
        pop     = fifo_en_i && rd_i && (count_q != '0);
        push_ok = fifo_en_i && push_i && ((count_q != FULL_LVL) || pop);
        drop    = fifo_en_i && push_i && !push_ok;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= push_entry_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q      <= '0;
            rp_q      <= '0;
            count_q   <= '0;
            buf_q     <= '0;
            bvalid_q  <= 1'b0;
            ovr_o     <= 1'b0;
            rd_data_o <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + 1'b1;
            if (pop)     rp_q <= rp_q + 1'b1;
            unique case ({push_ok, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (!fifo_en_i && push_i) begin
                buf_q    <= push_entry_i;
                bvalid_q <= 1'b1;
            end else if (!fifo_en_i && rd_i) begin
                bvalid_q <= 1'b0;
            end
            if (rd_i) begin
                if (!fifo_en_i) rd_data_o <= {ovr_o, buf_q};
                else if (pop)   rd_data_o <= {ovr_o, mem[rp_q]};
                else            rd_data_o <= {ovr_o, rd_data_o[9:0]};
            end
            if (drop)      ovr_o <= 1'b1;
            else if (rd_i) ovr_o <= 1'b0;
        end
    end

    assign avail_o = fifo_en_i ? (count_q != '0) : bvalid_q;
    assign level_o = count_q;
endmodule

// File: rtl/uart_rx_err_fifo.sv
module uart_rx_err_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       wlen_i,
    input  logic             par_en_i,
    input  logic             par_even_i,
    input  logic             fifo_en_i,
    input  logic             rd_i,
    output logic [10:0]      rd_data_o,
    output logic             rx_avail_o
);
    localparam int AW = $clog2(DEPTH);

    logic [1:0]  sync_q;
    logic        tick;
    logic        frame_done;
    rx_entry_t   frame_entry;
    logic [AW:0] fifo_level;
    logic        ovr_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    urx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .tick_o (tick)
    );

    urx_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .rx_i       (sync_q[1]),
        .wlen_i     (wlen_i),
        .par_en_i   (par_en_i),
        .par_even_i (par_even_i),
        .done_o     (frame_done),
        .entry_o    (frame_entry)
    );

    urx_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en_i    (fifo_en_i),
        .push_i       (frame_done),
        .push_entry_i (frame_entry),
        .rd_i         (rd_i),
        .rd_data_o    (rd_data_o),
        .avail_o      (rx_avail_o),
        .level_o      (fifo_level),
        .ovr_o        (ovr_flag)
    );
endmodule

// File: rtl/uart_rx_err_fifo_chk.sv
module uart_rx_err_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_i,
    input logic        fifo_en_i,
    input logic        rx_avail_o,
    input logic [10:0] rd_data_o,
    input logic [AW:0] level,
    input logic        ovr,
    input logic        done
);
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH[AW:0]);

    p_empty_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && fifo_en_i && !rx_avail_o) |=> (rd_data_o[9:0] == $past(rd_data_o[9:0])));

    p_ovr_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done) |=> !ovr);

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !rd_i) |=> ovr);

    p_no_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o));

    p_avail_after_char_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fifo_en_i) |=> rx_avail_o);
endmodule

bind uart_rx_err_fifo uart_rx_err_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (rd_i),
    .fifo_en_i  (fifo_en_i),
    .rx_avail_o (rx_avail_o),
    .rd_data_o  (rd_data_o),
    .level      (fifo_level),
    .ovr        (ovr_flag),
    .done       (frame_done)
);

// File: tb/uart_rx_err_fifo_tb_top.sv
module uart_rx_err_fifo_tb_top;
    localparam int DIV  = 2;
    localparam int BITC = 16 * (DIV + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_i = 1'b1;
    logic [11:0] div_i = 12'(DIV);
    logic [1:0]  wlen_i = 2'b11;
    logic        par_en_i = 1'b0;
    logic        par_even_i = 1'b1;
    logic        fifo_en_i = 1'b1;
    logic        rd_i = 1'b0;
    logic [10:0] rd_data_o;
    logic        rx_avail_o;

    int checks = 0;
    int errs = 0;
    bit live = 0;
    bit done_flag = 0;

    // behavioural reference model
    logic [9:0]  q[$];
    bit          m_ovr = 0;
    logic [9:0]  m_buf = '0;
    bit          m_bvalid = 0;
    logic [9:0]  m_last = '0;
    logic [10:0] exp_rd = '0;

    always #4 clk = ~clk;

    uart_rx_err_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .div_i(div_i),
        .wlen_i(wlen_i), .par_en_i(par_en_i), .par_even_i(par_even_i),
        .fifo_en_i(fifo_en_i), .rd_i(rd_i),
        .rd_data_o(rd_data_o), .rx_avail_o(rx_avail_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R11: every clock, the read port must equal the model's last read result
    always @(posedge clk) begin
        #2;
        if (live) chk("R11", 32'(rd_data_o), 32'(exp_rd));
    end

    task automatic bit_out(input logic b);
        rx_i = b;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int   nb = int'(wlen_i) + 5;
        logic [7:0] md = d & 8'((1 << nb) - 1);
        logic p;
        logic [9:0] ent;
        @(negedge clk);
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) bit_out(md[i]);
        if (par_en_i) begin
            p = (^md) ^ ~par_even_i;
            bit_out(bad_par ? ~p : p);
        end
        bit_out(bad_stop ? 1'b0 : 1'b1);
        rx_i = 1'b1;
        repeat (2 * BITC) @(negedge clk);
        ent = {par_en_i & bad_par, bad_stop, md};
        if (fifo_en_i) begin
            if (q.size() == 16) m_ovr = 1;
            else q.push_back(ent);
        end else begin
            m_buf = ent;
            m_bvalid = 1;
        end
    endtask

    task automatic do_read(input string req);
        @(negedge clk);
        chk(req, 32'(rx_avail_o), fifo_en_i ? 32'(q.size() > 0) : 32'(m_bvalid));
        if (fifo_en_i) begin
            if (q.size() > 0) m_last = q.pop_front();
            exp_rd = {m_ovr, m_last};
        end else begin
            exp_rd = {m_ovr, m_buf};
            m_bvalid = 0;
        end
        m_ovr = 0;
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        chk(req, 32'(rd_data_o), 32'(exp_rd));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errs++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1", 32'(rd_data_o), 32'h0);
        chk("R1", 32'(rx_avail_o), 32'h0);
        rst_n = 1'b1;
        live = 1;
        repeat (3 * BITC) @(negedge clk);

        // R2/R3: 8-bit words, no parity, queue order
        send(8'hA5, 0, 0);
        send(8'h3C, 0, 0);
        send(8'hFF, 0, 0);
        do_read("R3");
        do_read("R3");
        do_read("R2");

        // R2: short words with upper bits forced zero
        wlen_i = 2'b00;
        send(8'hFF, 0, 0);
        wlen_i = 2'b01;
        send(8'hEA, 0, 0);
        do_read("R2");
        do_read("R2");

        // R6: parity in both senses, good and bad
        wlen_i = 2'b10;
        par_en_i = 1'b1;
        par_even_i = 1'b1;
        send(8'h55, 0, 0);
        send(8'h13, 1, 0);
        par_even_i = 1'b0;
        send(8'h6B, 0, 0);
        send(8'h01, 1, 0);
        do_read("R6");
        do_read("R6");
        do_read("R6");
        do_read("R6");

        // R5: framing error
        wlen_i = 2'b11;
        par_en_i = 1'b0;
        send(8'h81, 0, 1);
        send(8'h42, 0, 0);
        do_read("R5");
        do_read("R5");

        // R8: read of empty queue
        do_read("R8");

        // R4/R7: fill to 16, one more is dropped
        for (int i = 0; i < 17; i++) send(8'(8'h10 + i), 0, 0);
        do_read("R7");
        for (int i = 0; i < 15; i++) do_read("R4");
        do_read("R8");
        chk("R4", 32'(rx_avail_o), 32'h0);

        // R10: short glitch on idle line
        @(negedge clk);
        rx_i = 1'b0;
        repeat (4 * (DIV + 1)) @(negedge clk);
        rx_i = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        chk("R10", 32'(rx_avail_o), 32'h0);
        send(8'h5A, 0, 0);
        do_read("R10");

        // R9: single buffer keeps only the newest character
        fifo_en_i = 1'b0;
        send(8'h11, 0, 0);
        send(8'h22, 0, 1);
        do_read("R9");
        do_read("R9");
        chk("R9", 32'(rx_avail_o), 32'h0);

        done_flag = 1;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule